// File: doc/BRIEF.md
# Four-Channel Fly-By Byte DMA Sequencer

This block moves bytes between peripherals and memory without the processor touching the data. Each of four channels has a request line from its peripheral. The block picks one eligible channel and asks the host for the bus with a hold-request / hold-acknowledge handshake. Once the host grants the bus, the block drives an active-low acknowledge to that peripheral. For each byte it then puts a 24-bit address on the bus and pulses one memory strobe and one IO strobe. The data moves directly between the two, so it never passes through this block.

Every channel holds a 16-bit current address, a 16-bit remaining count and an 8-bit page byte. The page byte forms the top of the address and is never carried into, so a transfer wraps inside its 64 KiB page. A channel runs in one of four modes: single, block, demand or cascade. In cascade mode another bus master takes over: the block asserts only the acknowledge line and leaves the address and strobes idle. When the count runs out, the block pulses a shared end-of-process line and the channel goes idle until it is loaded again. Channels are programmed through simple parallel load inputs, and a separate write sets all four mask bits at once.

Top module: `dma_byte_seq`

## Requirements
- R1: During and right after reset, hold request, address enable, all four strobes and end-of-process are low, and every acknowledge is high. Every channel starts masked and disarmed.
- R2: A channel is eligible when all three of these hold: its request is high, its mask bit is 0 and it is armed. A load arms the channel. Among eligible channels, the lowest index is chosen. A masked channel never causes a hold request.
- R3: A new hold request is raised only while hold acknowledge is low. An acknowledge is asserted only after hold acknowledge has been seen high, and never for more than one channel at a time.
- R4: In each byte cycle, address enable is high and the address is {page, current address}. With direction bit 1, IO read and memory write each pulse for that one cycle; with direction bit 0, memory read and IO write pulse instead. After the byte, the address goes up by 1 and the count goes down by 1. The address output is zero whenever address enable is low.
- R5: A current address of 0xFFFF steps to 0x0000 and the page byte stays the same.
- R6: A byte moved while the count is 0 is the last one. End-of-process is high in that byte cycle, the bus is released and the channel is disarmed, so a loaded count N moves N+1 bytes.
- R7: In single mode (mode code 1), the bus is released after every byte. Another byte needs a new arbitration.
- R8: In block mode (mode code 2), bytes move on consecutive cycles until terminal count, even if the request drops once the acknowledge has been given.
- R9: In demand mode (mode code 0), a byte cycle in which the request is seen low is the last one before the bus is released. A later request resumes from the stored address and count.
- R10: In cascade mode (mode code 3), only the acknowledge is driven: no address enable, no strobes and no change to the count. The bus is released after a cycle in which the request is seen low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_i | input | NCH | Per-channel transfer request |
| hold_ack_i | input | 1 | Bus grant from the host |
| hold_req_o | output | 1 | Bus request to the host |
| ack_n_o | output | NCH | Active-low per-channel acknowledge |
| cfg_load_i | input | 1 | Load and arm the channel chosen by cfg_chan_i |
| cfg_chan_i | input | log2(NCH) | Channel to load |
| cfg_addr_i | input | AW | Starting address |
| cfg_page_i | input | PW | Page byte |
| cfg_count_i | input | CW | Count (bytes minus one) |
| cfg_mode_i | input | 2 | Mode code: 0 demand, 1 single, 2 block, 3 cascade |
| cfg_dir_i | input | 1 | 1: IO to memory, 0: memory to IO |
| mask_we_i | input | 1 | Write all mask bits |
| mask_i | input | NCH | New mask bits (1 = masked) |
| addr_en_o | output | 1 | Address bus valid |
| addr_o | output | AW+PW | Bus address |
| mem_rd_o | output | 1 | Memory read strobe |
| mem_wr_o | output | 1 | Memory write strobe |
| io_rd_o | output | 1 | IO read strobe |
| io_wr_o | output | 1 | IO write strobe |
| eop_o | output | 1 | End-of-process pulse |

## Verification
The hardest case to reach from the ports is demand-mode suspension and resumption. The request has to drop in the middle of a run, and the channel must later carry on from exactly the address and count it had stopped at. The stimulus watches the byte cycles on the bus and drops the request only after a few bytes have gone by. It then holds the request low until the bus has been released, raises it again, and checks the total byte count and the final address. The page wrap is reached by loading a start address just below 0xFFFF in block mode, so the carry-free step happens in the middle of a burst.

// File: rtl/dma_seq_pkg.sv
package dma_seq_pkg;

    typedef enum logic [1:0] {
        MODE_DEMAND  = 2'd0,
        MODE_SINGLE  = 2'd1,
        MODE_BLOCK   = 2'd2,
        MODE_CASCADE = 2'd3
    } xfer_mode_e;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_HOLD = 2'd1,
        ST_XFER = 2'd2
    } seq_state_e;

endpackage

// File: rtl/dma_chan_regs.sv
module dma_chan_regs import dma_seq_pkg::*; #(
    parameter int AW = 16,
    parameter int PW = 8,
    parameter int CW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load_i,
    input  logic [AW-1:0] addr_i,
    input  logic [PW-1:0] page_i,
    input  logic [CW-1:0] count_i,
    input  xfer_mode_e    mode_i,
    input  logic          dir_i,
    input  logic          mask_we_i,
    input  logic          mask_i,
    input  logic          step_i,
    input  logic          tc_i,
    output logic [AW-1:0] addr_o,
    output logic [PW-1:0] page_o,
    output logic [CW-1:0] count_o,
    output xfer_mode_e    mode_o,
    output logic          dir_o,
    output logic          mask_o,
    output logic          armed_o
);

    typedef struct packed {
        logic [AW-1:0] addr;
        logic [PW-1:0] page;
        logic [CW-1:0] count;
        xfer_mode_e    mode;
        logic          dir;
        logic          mask;
        logic          armed;
    } chan_s;

    chan_s chan_d, chan_q;

    always_comb begin
        chan_d = chan_q;
        if (step_i) begin
            chan_d.addr  = chan_q.addr + 1'b1;   // page is not touched: wraps in page
            chan_d.count = chan_q.count - 1'b1;
            if (tc_i) begin
                chan_d.armed = 1'b0;
            end
        end
        if (mask_we_i) begin
            chan_d.mask = mask_i;
        end
        if (load_i) begin
            chan_d.addr  = addr_i;
            chan_d.page  = page_i;
            chan_d.count = count_i;
            chan_d.mode  = mode_i;
            chan_d.dir   = dir_i;
            chan_d.armed = 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            chan_q       <= '0;
            chan_q.mode  <= MODE_DEMAND;
            chan_q.mask  <= 1'b1;
        end else begin
            chan_q <= chan_d;
        end
    end

    assign addr_o  = chan_q.addr;
    assign page_o  = chan_q.page;
    assign count_o = chan_q.count;
    assign mode_o  = chan_q.mode;
    assign dir_o   = chan_q.dir;
    assign mask_o  = chan_q.mask;
    assign armed_o = chan_q.armed;

endmodule

// File: rtl/dma_prio_pick.sv
module dma_prio_pick #(
    parameter int NCH = 4,
    localparam int IW = (NCH > 1) ? $clog2(NCH) : 1
) (
    input  logic [NCH-1:0] elig_i,
    output logic           any_o,
    output logic [IW-1:0]  idx_o
);

    // Fixed priority: scanning downward lets the lowest index win.
    always_comb begin
        idx_o = '0;
        for (int c = NCH - 1; c >= 0; c--) begin
            if (elig_i[c]) begin
                idx_o = IW'(c);
            end
        end
    end

    assign any_o = |elig_i;

endmodule

// File: rtl/dma_seq_fsm.sv
module dma_seq_fsm import dma_seq_pkg::*; #(
    parameter int NCH = 4,
    localparam int IW = (NCH > 1) ? $clog2(NCH) : 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          hold_ack_i,
    input  logic          elig_any_i,
    input  logic [IW-1:0] pick_i,
    input  logic          req_sel_i,
    input  xfer_mode_e    mode_sel_i,
    input  logic          count_zero_i,
    output seq_state_e    state_o,
    output logic [IW-1:0] sel_o,
    output logic          step_o,
    output logic          tc_o
);

    typedef struct packed {
        seq_state_e    state;
        logic [IW-1:0] sel;
    } seq_s;

    seq_s seq_d, seq_q;
    logic xfer_byte;

    assign xfer_byte = (seq_q.state == ST_XFER) && (mode_sel_i != MODE_CASCADE);

    always_comb begin
        seq_d = seq_q;
        case (seq_q.state)
            ST_IDLE: begin
                if (!hold_ack_i && elig_any_i) begin
                    seq_d.state = ST_HOLD;
                    seq_d.sel   = pick_i;
                end
            end
            ST_HOLD: begin
                if (hold_ack_i) begin
                    seq_d.state = ST_XFER;
                end
            end
            ST_XFER: begin
                if (mode_sel_i == MODE_CASCADE) begin
                    if (!req_sel_i) begin
                        seq_d.state = ST_IDLE;
                    end
                end else if (count_zero_i) begin
                    seq_d.state = ST_IDLE;
                end else begin
                    case (mode_sel_i)
                        MODE_SINGLE: seq_d.state = ST_IDLE;
                        MODE_DEMAND: if (!req_sel_i) seq_d.state = ST_IDLE;
                        default: ;
                    endcase
                end
            end
            default: seq_d.state = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            seq_q.state <= ST_IDLE;
            seq_q.sel   <= '0;
        end else begin
            seq_q <= seq_d;
        end
    end

    assign state_o = seq_q.state;
    assign sel_o   = seq_q.sel;
    assign step_o  = xfer_byte;
    assign tc_o    = xfer_byte && count_zero_i;

endmodule

// File: rtl/dma_byte_seq.sv
module dma_byte_seq import dma_seq_pkg::*; #(
    parameter int NCH = 4,
    parameter int AW  = 16,
    parameter int PW  = 8,
    parameter int CW  = 16,
    localparam int IW = (NCH > 1) ? $clog2(NCH) : 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [NCH-1:0]   req_i,
    input  logic             hold_ack_i,
    output logic             hold_req_o,
    output logic [NCH-1:0]   ack_n_o,
    input  logic             cfg_load_i,
    input  logic [IW-1:0]    cfg_chan_i,
    input  logic [AW-1:0]    cfg_addr_i,
    input  logic [PW-1:0]    cfg_page_i,
    input  logic [CW-1:0]    cfg_count_i,
    input  logic [1:0]       cfg_mode_i,
    input  logic             cfg_dir_i,
    input  logic             mask_we_i,
    input  logic [NCH-1:0]   mask_i,
    output logic             addr_en_o,
    output logic [AW+PW-1:0] addr_o,
    output logic             mem_rd_o,
    output logic             mem_wr_o,
    output logic             io_rd_o,
    output logic             io_wr_o,
    output logic             eop_o
);

    logic [AW-1:0]  ch_addr  [NCH];
    logic [PW-1:0]  ch_page  [NCH];
    logic [CW-1:0]  ch_count [NCH];
    xfer_mode_e     ch_mode  [NCH];
    logic [NCH-1:0] ch_dir, ch_mask, ch_armed, elig;

    seq_state_e     state;
    logic [IW-1:0]  sel, pick;
    logic           step, tc, elig_any;

    generate
        for (genvar c = 0; c < NCH; c++) begin : g_chan
            dma_chan_regs #(.AW(AW), .PW(PW), .CW(CW)) i_regs (
                .clk       (clk),
                .rst_n     (rst_n),
                .load_i    (cfg_load_i && (cfg_chan_i == IW'(c))),
                .addr_i    (cfg_addr_i),
                .page_i    (cfg_page_i),
                .count_i   (cfg_count_i),
                .mode_i    (xfer_mode_e'(cfg_mode_i)),
                .dir_i     (cfg_dir_i),
                .mask_we_i (mask_we_i),
                .mask_i    (mask_i[c]),
                .step_i    (step && (sel == IW'(c))),
                .tc_i      (tc),
                .addr_o    (ch_addr[c]),
                .page_o    (ch_page[c]),
                .count_o   (ch_count[c]),
                .mode_o    (ch_mode[c]),
                .dir_o     (ch_dir[c]),
                .mask_o    (ch_mask[c]),
                .armed_o   (ch_armed[c])
            );
            assign elig[c] = req_i[c] && !ch_mask[c] && ch_armed[c];
        end
    endgenerate

    dma_prio_pick #(.NCH(NCH)) i_pick (
        .elig_i (elig),
        .any_o  (elig_any),
        .idx_o  (pick)
    );

    dma_seq_fsm #(.NCH(NCH)) i_fsm (
        .clk          (clk),
        .rst_n        (rst_n),
        .hold_ack_i   (hold_ack_i),
        .elig_any_i   (elig_any),
        .pick_i       (pick),
        .req_sel_i    (req_i[sel]),
        .mode_sel_i   (ch_mode[sel]),
        .count_zero_i (ch_count[sel] == '0),
        .state_o      (state),
        .sel_o        (sel),
        .step_o       (step),
        .tc_o         (tc)
    );

    always_comb begin
        ack_n_o = '1;
        if (state == ST_XFER) begin
            ack_n_o[sel] = 1'b0;
        end
    end

    assign hold_req_o = (state != ST_IDLE);
    assign addr_en_o  = step;
    assign addr_o     = step ? {ch_page[sel], ch_addr[sel]} : '0;
    assign io_rd_o    = step &&  ch_dir[sel];
    assign mem_wr_o   = step &&  ch_dir[sel];
    assign mem_rd_o   = step && !ch_dir[sel];
    assign io_wr_o    = step && !ch_dir[sel];
    assign eop_o      = tc;

endmodule

// File: rtl/dma_byte_seq_chk.sv
module dma_byte_seq_chk #(
    parameter int NCH = 4,
    parameter int AW  = 16,
    parameter int PW  = 8
) (
    input logic             clk,
    input logic             rst_n,
    input logic             hold_ack_i,
    input logic             hold_req_o,
    input logic [NCH-1:0]   ack_n_o,
    input logic             addr_en_o,
    input logic [AW+PW-1:0] addr_o,
    input logic             mem_rd_o,
    input logic             mem_wr_o,
    input logic             io_rd_o,
    input logic             io_wr_o,
    input logic             eop_o
);

    p_one_ack_r3: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(~ack_n_o));

    p_ack_in_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (~ack_n_o != '0) |-> hold_req_o);

    p_rise_after_ack_low_r3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(hold_req_o) |-> !$past(hold_ack_i));

    p_strobe_pair_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_rd_o || mem_wr_o || io_rd_o || io_wr_o) |->
            (($countones({mem_rd_o, mem_wr_o, io_rd_o, io_wr_o}) == 2)
             && (mem_rd_o == io_wr_o) && addr_en_o && (~ack_n_o != '0)));

    p_addr_idle_zero_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !addr_en_o |-> (addr_o == '0));

    p_step_wrap_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (addr_en_o && $past(addr_en_o)) |->
            ((addr_o[AW-1:0] == AW'($past(addr_o[AW-1:0]) + 1'b1))
             && (addr_o[AW+PW-1:AW] == $past(addr_o[AW+PW-1:AW]))));

    p_eop_on_byte_r6: assert property (@(posedge clk) disable iff (!rst_n)
        eop_o |-> addr_en_o);

    p_eop_release_r6: assert property (@(posedge clk) disable iff (!rst_n)
        eop_o |=> !hold_req_o);

endmodule

bind dma_byte_seq dma_byte_seq_chk #(.NCH(NCH), .AW(AW), .PW(PW)) i_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .hold_ack_i (hold_ack_i),
    .hold_req_o (hold_req_o),
    .ack_n_o    (ack_n_o),
    .addr_en_o  (addr_en_o),
    .addr_o     (addr_o),
    .mem_rd_o   (mem_rd_o),
    .mem_wr_o   (mem_wr_o),
    .io_rd_o    (io_rd_o),
    .io_wr_o    (io_wr_o),
    .eop_o      (eop_o)
);

// File: tb/test_dma_byte_seq.sv
`timescale 1ns/1ps
module test_dma_byte_seq;

    localparam int NCH = 4;
    localparam int AW  = 16;
    localparam int PW  = 8;
    localparam int CW  = 16;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic [NCH-1:0]   req = '0;
    logic             hold_ack = 1'b0;
    logic             hold_req;
    logic [NCH-1:0]   ack_n;
    logic             cfg_load = 1'b0;
    logic [1:0]       cfg_chan = '0;
    logic [AW-1:0]    cfg_addr = '0;
    logic [PW-1:0]    cfg_page = '0;
    logic [CW-1:0]    cfg_count = '0;
    logic [1:0]       cfg_mode = '0;
    logic             cfg_dir = 1'b0;
    logic             mask_we = 1'b0;
    logic [NCH-1:0]   mask_v = '1;
    logic             addr_en;
    logic [AW+PW-1:0] addr;
    logic             mem_rd, mem_wr, io_rd, io_wr, eop;

    always #2.5 clk = ~clk;

    dma_byte_seq #(.NCH(NCH), .AW(AW), .PW(PW), .CW(CW)) i_dma_byte_seq (
        .clk(clk), .rst_n(rst_n), .req_i(req), .hold_ack_i(hold_ack),
        .hold_req_o(hold_req), .ack_n_o(ack_n),
        .cfg_load_i(cfg_load), .cfg_chan_i(cfg_chan), .cfg_addr_i(cfg_addr),
        .cfg_page_i(cfg_page), .cfg_count_i(cfg_count), .cfg_mode_i(cfg_mode),
        .cfg_dir_i(cfg_dir), .mask_we_i(mask_we), .mask_i(mask_v),
        .addr_en_o(addr_en), .addr_o(addr), .mem_rd_o(mem_rd), .mem_wr_o(mem_wr),
        .io_rd_o(io_rd), .io_wr_o(io_wr), .eop_o(eop)
    );

    int n_cmp = 0;
    int n_bad = 0;
    bit fin = 0;

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_cmp++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    // ---------------- behavioural reference model ----------------
    int mst = 0, msel = 0, nst, nsel;
    bit stp, tcm;
    int m_addr[NCH], m_page[NCH], m_cnt[NCH], m_mode[NCH], m_dir[NCH], m_arm[NCH], m_mask[NCH];

    always @(posedge clk) begin
        if (!rst_n) begin
            mst = 0; msel = 0;
            for (int c = 0; c < NCH; c++) begin
                m_addr[c] = 0; m_page[c] = 0; m_cnt[c] = 0; m_mode[c] = 0;
                m_dir[c] = 0; m_arm[c] = 0; m_mask[c] = 1;
            end
        end else begin
            nst = mst; nsel = msel; stp = 0; tcm = 0;
            if (mst == 0) begin
                if (!hold_ack)
                    for (int c = NCH - 1; c >= 0; c--)
                        if (req[c] && m_mask[c] == 0 && m_arm[c] == 1) begin nst = 1; nsel = c; end
            end else if (mst == 1) begin
                if (hold_ack) nst = 2;
            end else begin
                if (m_mode[msel] == 3) begin
                    if (!req[msel]) nst = 0;
                end else begin
                    stp = 1;
                    tcm = (m_cnt[msel] == 0);
                    if (tcm || m_mode[msel] == 1 || (m_mode[msel] == 0 && !req[msel])) nst = 0;
                end
            end
            if (stp) begin
                m_addr[msel] = (m_addr[msel] + 1) % 65536;
                m_cnt[msel]  = (m_cnt[msel] + 65535) % 65536;
                if (tcm) m_arm[msel] = 0;
            end
            if (mask_we) for (int c = 0; c < NCH; c++) m_mask[c] = mask_v[c];
            if (cfg_load) begin
                m_addr[cfg_chan] = cfg_addr; m_page[cfg_chan] = cfg_page;
                m_cnt[cfg_chan] = cfg_count; m_mode[cfg_chan] = cfg_mode;
                m_dir[cfg_chan] = cfg_dir; m_arm[cfg_chan] = 1;
            end
            mst = nst; msel = nsel;
        end
    end

    // ---------------- compare, monitor, host ----------------
    int hdly = 1, hcnt = 0;
    int bytes[NCH], ackc[NCH];
    int holdrise = 0, eops = 0, first_ack = -1, last_ack = -1;
    int n_memrd = 0, n_memwr = 0, n_iord = 0, n_iowr = 0;
    int bad_ack = 0, bad_rise = 0;
    logic [23:0] last_addr = '0;
    logic [23:0] alog[$];
    bit prev_hold = 0;
    bit e_hold, e_byte, e_eop;
    logic [NCH-1:0] e_ack;
    logic [23:0] e_addr;

    initial for (int c = 0; c < NCH; c++) begin bytes[c] = 0; ackc[c] = 0; end

    always @(negedge clk) begin
        if (rst_n && !fin) begin
            e_hold = (mst != 0);
            e_ack  = '1;
            if (mst == 2) e_ack[msel] = 1'b0;
            e_byte = (mst == 2) && (m_mode[msel] != 3);
            e_addr = e_byte ? 24'((m_page[msel] << 16) | m_addr[msel]) : 24'h0;
            e_eop  = e_byte && (m_cnt[msel] == 0);
            chk(hold_req == e_hold, "R3 hold_req", 32'(hold_req), 32'(e_hold));
            chk(ack_n == e_ack, "R3 ack_n", 32'(ack_n), 32'(e_ack));
            chk(addr_en == e_byte && addr == e_addr, "R4 address", 32'(addr), 32'(e_addr));
            chk({mem_rd, mem_wr, io_rd, io_wr} ==
                {e_byte && !m_dir[msel][0], e_byte && m_dir[msel][0], e_byte && m_dir[msel][0], e_byte && !m_dir[msel][0]},
                "R4 strobes", 32'({mem_rd, mem_wr, io_rd, io_wr}), 32'(e_byte));
            chk(eop == e_eop, "R6 eop", 32'(eop), 32'(e_eop));
            // monitor from ports
            if (hold_req && !prev_hold) begin holdrise++; if (hold_ack) bad_rise++; end
            prev_hold = hold_req;
            for (int c = 0; c < NCH; c++) if (!ack_n[c]) begin
                ackc[c]++;
                if (!hold_ack) bad_ack++;
                if (first_ack < 0) first_ack = c;
                last_ack = c;
                if (addr_en) bytes[c]++;
            end
            if (addr_en) begin last_addr = addr; alog.push_back(addr); end
            if (eop) eops++;
            if (mem_rd) n_memrd++;
            if (mem_wr) n_memwr++;
            if (io_rd) n_iord++;
            if (io_wr) n_iowr++;
            // host grants hold after hdly cycles, drops it as soon as request falls
            if (!e_hold) begin hold_ack = 1'b0; hcnt = 0; end
            else if (!hold_ack) begin
                if (hcnt >= hdly) hold_ack = 1'b1; else hcnt++;
            end
        end
    end

    // ---------------- stimulus helpers ----------------
    task automatic wait_cyc(input int n);
        repeat (n) @(negedge clk);
        #1;
    endtask

    task automatic load(input int ch, input int a, input int pg, input int cnt, input int md, input int dir);
        @(negedge clk);
        cfg_chan = 2'(ch); cfg_addr = AW'(a); cfg_page = PW'(pg);
        cfg_count = CW'(cnt); cfg_mode = 2'(md); cfg_dir = dir[0]; cfg_load = 1'b1;
        @(negedge clk);
        cfg_load = 1'b0;
    endtask

    task automatic set_mask(input logic [NCH-1:0] m);
        @(negedge clk);
        mask_v = m; mask_we = 1'b1;
        @(negedge clk);
        mask_we = 1'b0;
    endtask

    int snap, snap2, tries;

    always @(posedge clk) begin : watchdog
        int cyc;
        cyc++;
        if (cyc > 150000 && !fin) begin
            fin = 1;
            n_cmp++; n_bad++;
            $display("FAIL watchdog: actual %0d expected below 150000 cycles", cyc);
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        // R1: reset state
        repeat (3) @(negedge clk);
        #1;
        chk(!hold_req && ack_n == '1 && !addr_en && !eop, "R1 reset outputs",
            32'({hold_req, ack_n, addr_en, eop}), 32'({1'b0, 4'hF, 1'b0, 1'b0}));
        chk({mem_rd, mem_wr, io_rd, io_wr} == 4'b0, "R1 reset strobes",
            32'({mem_rd, mem_wr, io_rd, io_wr}), 32'h0);
        @(negedge clk);
        rst_n = 1'b1;
        wait_cyc(2);
        chk(!hold_req && ack_n == '1, "R1 after reset", 32'({hold_req, ack_n}), 32'h0F);

        // R2: masked channel is ignored; R7 single mode; R6 terminal count
        hdly = 1;
        load(2, 'h1000, 'h34, 2, 1, 1);
        req[2] = 1'b1;
        wait_cyc(10);
        chk(holdrise == 0, "R2 masked channel", 32'(holdrise), 32'h0);
        set_mask(4'b1011);
        wait_cyc(40);
        chk(bytes[2] == 3, "R6 count 2 moves 3 bytes", 32'(bytes[2]), 32'h3);
        chk(holdrise == 3, "R7 release per byte", 32'(holdrise), 32'h3);
        chk(eops == 1, "R6 single eop", 32'(eops), 32'h1);
        chk(last_addr == 24'h341002, "R4 page and address", 32'(last_addr), 32'h341002);
        chk(n_iord == 3 && n_memwr == 3 && n_memrd == 0, "R4 direction 1 strobes",
            32'({n_iord[7:0], n_memwr[7:0], n_memrd[7:0]}), 32'h030300);
        wait_cyc(10);
        chk(bytes[2] == 3 && holdrise == 3, "R6 disarmed after tc", 32'(holdrise), 32'h3);
        req[2] = 1'b0;

        // R8 block mode with short request, R5 wrap in page
        hdly = 2;
        alog.delete();
        load(1, 'hFFFE, 'h12, 4, 2, 0);
        set_mask(4'b1001);
        @(negedge clk);
        req[1] = 1'b1;
        tries = 0;
        do begin @(negedge clk); #1; tries++; end while (ack_n[1] && tries < 50);
        req[1] = 1'b0;
        wait_cyc(20);
        chk(bytes[1] == 5, "R8 block runs to tc", 32'(bytes[1]), 32'h5);
        chk(alog.size() == 5, "R8 block byte log", 32'(alog.size()), 32'h5);
        if (alog.size() == 5) begin
            chk(alog[1] == 24'h12FFFF, "R5 before wrap", 32'(alog[1]), 32'h12FFFF);
            chk(alog[2] == 24'h120000, "R5 wrap keeps page", 32'(alog[2]), 32'h120000);
            chk(alog[4] == 24'h120002, "R5 after wrap", 32'(alog[4]), 32'h120002);
        end
        chk(n_memrd == 5 && n_iowr == 5, "R4 direction 0 strobes",
            32'({n_memrd[7:0], n_iowr[7:0]}), 32'h0505);

        // R9 demand mode suspend and resume
        hdly = 0;
        load(3, 'h0200, 'h05, 9, 0, 1);
        set_mask(4'b0001);
        snap = eops;
        @(negedge clk);
        req[3] = 1'b1;
        tries = 0;
        do begin @(negedge clk); #1; tries++; end while (bytes[3] < 4 && tries < 50);
        req[3] = 1'b0;
        wait_cyc(10);
        chk(!hold_req, "R9 bus released on drop", 32'(hold_req), 32'h0);
        chk(bytes[3] < 10 && eops == snap, "R9 suspended mid run", 32'(bytes[3]), 32'h4);
        @(negedge clk);
        req[3] = 1'b1;
        wait_cyc(30);
        chk(bytes[3] == 10, "R9 resumed total", 32'(bytes[3]), 32'hA);
        chk(last_addr == 24'h050209, "R9 resumed address", 32'(last_addr), 32'h050209);
        chk(eops == snap + 1, "R9 eop at end", 32'(eops), 32'(snap + 1));
        req[3] = 1'b0;

        // R2 fixed priority
        hdly = 1;
        load(0, 'h0010, 'h00, 1, 1, 0);
        load(3, 'h0300, 'h00, 0, 1, 0);
        set_mask(4'b0000);
        wait_cyc(3);
        first_ack = -1;
        snap = bytes[0]; snap2 = bytes[3];
        @(negedge clk);
        req[0] = 1'b1; req[3] = 1'b1;
        wait_cyc(40);
        chk(first_ack == 0, "R2 lowest index first", 32'(first_ack), 32'h0);
        chk(last_ack == 3, "R2 lower priority later", 32'(last_ack), 32'h3);
        chk(bytes[0] - snap == 2 && bytes[3] - snap2 == 1, "R2 both served",
            32'({bytes[0] - snap, bytes[3] - snap2}), 32'h2);
        req[0] = 1'b0; req[3] = 1'b0;

        // R10 cascade
        load(1, 'h4000, 'h07, 5, 3, 1);
        wait_cyc(3);
        snap = n_memrd + n_memwr + n_iord + n_iowr;
        snap2 = ackc[1];
        @(negedge clk);
        req[1] = 1'b1;
        wait_cyc(12);
        chk(hold_req && !ack_n[1], "R10 ack held in cascade", 32'({hold_req, ack_n[1]}), 32'h2);
        chk(ackc[1] > snap2, "R10 ack cycles seen", 32'(ackc[1]), 32'(snap2 + 1));
        chk(n_memrd + n_memwr + n_iord + n_iowr == snap && !addr_en, "R10 no strobes",
            32'(n_memrd + n_memwr + n_iord + n_iowr), 32'(snap));
        req[1] = 1'b0;
        wait_cyc(8);
        chk(!hold_req && ack_n == '1, "R10 release on drop", 32'({hold_req, ack_n}), 32'h0F);

        // R3 handshake order over the whole run
        chk(bad_ack == 0, "R3 ack only with grant", 32'(bad_ack), 32'h0);
        chk(bad_rise == 0, "R3 request only with grant low", 32'(bad_rise), 32'h0);

        fin = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule